// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block supervises software by counting ticks of a slow timebase toward an overflow period of 2^E ticks. Software proves it is alive by writing a fixed key byte, 0xAC, to the block's write port. A write counts as a refresh only if it lands in the open part of the period, which is a trailing window of 25, 50, 75 or 100 percent of the period. A refresh that comes too early, a wrong key, or a period that ends without a refresh all raise a one-cycle reset request. After a reset request the count starts again from zero.

An early-warning interrupt can be enabled. It pulses once when the count reaches three quarters of the period. The count keeps running after the interrupt, so the software still has to refresh. The period exponent, window size and interrupt enable are static. The block captures them once, on the first clock edge after reset is released.

Top module: `wdog_win`

## Requirements
- R1: While rst_ni is low, irq_o and rst_req_o are 0 and the count is held at zero.
- R2: The configuration is captured on the first clock edge after reset release. Period code k selects exponent 7+k, and codes above 9 select 16. Later changes to the configuration inputs have no effect. A write or tick presented at that first edge is ignored.
- R3: The count advances by one only on cycles with tick_i high. When a tick would take the count to 2^E, rst_req_o pulses for one cycle after that edge and the count restarts at zero.
- R4: Window code 0 opens the last 25% of the period, 1 the last 50%, 2 the last 75%, and 3 the whole period. The count values below P·(1−fraction) are closed.
- R5: Writing 0xAC while the count is in the open window restarts the count from zero and raises no reset request.
- R6: Writing 0xAC while the count is in the closed window raises rst_req_o on the next cycle and restarts the count.
- R7: Writing any value other than 0xAC, at any count, raises rst_req_o on the next cycle and restarts the count.
- R8: With irq_en_i captured high, irq_o pulses for one cycle after the tick that brings the count to 3P/4. The count continues afterwards.
- R9: With irq_en_i captured low, irq_o never rises.
- R10: A write takes priority over a tick in the same cycle. A valid refresh at count P−1 with a tick therefore avoids the overflow.
- R11: After any reset request or refresh, the interrupt is re-armed and fires again in the following period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase enable; count advances when high |
| wr_en_i | input | 1 | Write strobe for the key byte |
| wr_data_i | input | 8 | Key byte; 0xAC refreshes |
| period_sel_i | input | 4 | Period exponent code (exponent 7+code, clamped at 16) |
| win_sel_i | input | 2 | Open window: 0=25%, 1=50%, 2=75%, 3=100% |
| irq_en_i | input | 1 | Early-warning interrupt enable |
| irq_o | output | 1 | One-cycle interrupt at 3/4 of the period |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
The counter is run with a tick on every cycle and with a tick on every fourth cycle. Comparing the two shows that the count follows the tick and not the clock. Key writes are placed one count below and exactly at the closed-window limit for each window code. This separates the four window sizes and catches off-by-one errors at the limit. Wrong keys inside the open window, a refresh coinciding with the final tick, and a configuration change after capture are each used to show priority and sampling rules. A run at the clamped largest period confirms the exponent decode.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    WIN_25  = 2'd0,
    WIN_50  = 2'd1,
    WIN_75  = 2'd2,
    WIN_100 = 2'd3
  } win_e;

  localparam logic [7:0] KEY_DEFAULT = 8'hAC;
endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter int EXP_MIN = 7,
  parameter int EXP_MAX = 16,
  parameter int SEL_W   = 4,
  parameter int CNT_W   = EXP_MAX + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic [1:0]       win_sel_i,
  input  logic             irq_en_i,
  output logic             vld_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] close_lim_o,
  output logic [CNT_W-1:0] irq_pt_o,
  output logic             irq_en_o
);
  localparam int SPAN = EXP_MAX - EXP_MIN;

  int               exp_w;
  logic [CNT_W-1:0] period_w, half_w, quarter_w, close_w;

  always_comb begin
    if (int'(period_sel_i) > SPAN) exp_w = EXP_MAX;
    else                           exp_w = EXP_MIN + int'(period_sel_i);
    period_w  = CNT_W'(1) << exp_w;
    half_w    = period_w >> 1;
    quarter_w = period_w >> 2;
    unique case (win_e'(win_sel_i))
      WIN_25:  close_w = half_w + quarter_w;
      WIN_50:  close_w = half_w;
      WIN_75:  close_w = quarter_w;
      default: close_w = '0;
    endcase
  end

  // one-shot capture on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      period_o    <= '0;
      close_lim_o <= '0;
      irq_pt_o    <= '0;
      irq_en_o    <= 1'b0;
    end else if (!vld_o) begin
      vld_o       <= 1'b1;
      period_o    <= period_w;
      close_lim_o <= close_w;
      irq_pt_o    <= half_w + quarter_w;
      irq_en_o    <= irq_en_i;
    end
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int CNT_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/wdog_ctl.sv
module wdog_ctl #(
  parameter int         CNT_W = 17,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] close_lim_i,
  input  logic [CNT_W-1:0] irq_pt_i,
  input  logic             irq_en_i,
  output logic             clr_o,
  output logic             inc_o,
  output logic             irq_o,
  output logic             rst_req_o
);
  logic armed_q;
  logic irq_evt, rst_evt, key_ok, in_open, last_tick;

  assign key_ok    = (wr_data_i == KEY);
  assign in_open   = (cnt_i >= close_lim_i);
  assign last_tick = (cnt_i == period_i - CNT_W'(1));

  // write beats tick; nothing acts before config is captured
  always_comb begin
    clr_o   = 1'b0;
    inc_o   = 1'b0;
    irq_evt = 1'b0;
    rst_evt = 1'b0;
    if (vld_i) begin
      if (wr_en_i) begin
        clr_o   = 1'b1;
        rst_evt = !(key_ok && in_open);
      end else if (tick_i) begin
        if (last_tick) begin
          clr_o   = 1'b1;
          rst_evt = 1'b1;
        end else begin
          inc_o   = 1'b1;
          irq_evt = irq_en_i && armed_q && ((cnt_i + CNT_W'(1)) == irq_pt_i);
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q   <= 1'b1;
      irq_o     <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      irq_o     <= irq_evt;
      rst_req_o <= rst_evt;
      if (clr_o)        armed_q <= 1'b1;
      else if (irq_evt) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_win.sv
module wdog_win
  import wdog_pkg::*;
#(
  parameter int         EXP_MIN = 7,
  parameter int         EXP_MAX = 16,
  parameter int         SEL_W   = 4,
  parameter logic [7:0] KEY     = KEY_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [SEL_W-1:0] period_sel_i,
  input  logic [1:0]       win_sel_i,
  input  logic             irq_en_i,
  output logic             irq_o,
  output logic             rst_req_o
);
  localparam int CNT_W = EXP_MAX + 1;

  logic             cfg_vld, cfg_irq_en, cnt_clr, cnt_inc;
  logic [CNT_W-1:0] period, close_lim, irq_pt, cnt_q;

  wdog_cfg #(
    .EXP_MIN(EXP_MIN), .EXP_MAX(EXP_MAX), .SEL_W(SEL_W), .CNT_W(CNT_W)
  ) i_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .period_sel_i(period_sel_i),
    .win_sel_i   (win_sel_i),
    .irq_en_i    (irq_en_i),
    .vld_o       (cfg_vld),
    .period_o    (period),
    .close_lim_o (close_lim),
    .irq_pt_o    (irq_pt),
    .irq_en_o    (cfg_irq_en)
  );

  wdog_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (cnt_inc),
    .cnt_o (cnt_q)
  );

  wdog_ctl #(.CNT_W(CNT_W), .KEY(KEY)) i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (cfg_vld),
    .tick_i     (tick_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .cnt_i      (cnt_q),
    .period_i   (period),
    .close_lim_i(close_lim),
    .irq_pt_i   (irq_pt),
    .irq_en_i   (cfg_irq_en),
    .clr_o      (cnt_clr),
    .inc_o      (cnt_inc),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
  );
endmodule

// File: rtl/wdog_win_chk.sv
module wdog_win_chk #(
  parameter int         CNT_W = 17,
  parameter logic [7:0] KEY   = 8'hAC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             cfg_vld,
  input logic             cfg_irq_en,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] period
);
  assert_bad_key_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_vld && wr_en_i && wr_data_i != KEY) |=> rst_req_o);

  assert_cnt_below_period_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_vld |-> (cnt_q < period));

  assert_restart_on_req_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_o |-> (cnt_q == '0));

  assert_irq_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cfg_irq_en);

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_irq_rst_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && rst_req_o));
endmodule

bind wdog_win wdog_win_chk #(.CNT_W(CNT_W), .KEY(KEY)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .cfg_vld   (cfg_vld),
  .cfg_irq_en(cfg_irq_en),
  .cnt_q     (cnt_q),
  .period    (period)
);

// File: tb/test_wdog_win.sv
module test_wdog_win;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] psel = 4'd0;
  logic [1:0] wsel = 2'd3;
  logic       ien = 1'b0;
  logic       irq, rreq;

  int    tests = 0, fails = 0, cyc = 0, ncyc = 0;
  int    n_irq = 0, n_rst = 0;
  bit    tick_on = 1'b0, sparse = 1'b0;
  string tag = "R1";

  // reference model state
  bit m_vld, m_irq, m_rst, m_armed, m_ien;
  int m_cnt, m_p, m_lim, m_e;

  always #2 clk = ~clk;

  wdog_win i_wdog_win (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .period_sel_i(psel), .win_sel_i(wsel),
    .irq_en_i(ien), .irq_o(irq), .rst_req_o(rreq)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_vld = 0; m_cnt = 0; m_irq = 0; m_rst = 0; m_armed = 1;
    end else begin
      m_irq = 0; m_rst = 0;
      if (!m_vld) begin
        m_vld = 1;
        m_e   = (psel > 4'd9) ? 16 : 7 + int'(psel);
        m_p   = 1 << m_e;
        m_ien = ien;
        m_lim = m_p - (m_p * (int'(wsel) + 1)) / 4;
      end else if (wr_en) begin
        if (!(wr_data == 8'hAC && m_cnt >= m_lim)) m_rst = 1;
        m_cnt = 0; m_armed = 1;
      end else if (tick) begin
        if (m_cnt == m_p - 1) begin
          m_rst = 1; m_cnt = 0; m_armed = 1;
        end else begin
          m_cnt++;
          if (m_ien && m_armed && m_cnt == (m_p * 3) / 4) begin
            m_irq = 1; m_armed = 0;
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    ncyc++;
    tick = sparse ? (ncyc % 4 == 0) : tick_on;
    chk(irq == m_irq, {tag, " irq"}, int'(irq), int'(m_irq));
    chk(rreq == m_rst, {tag, " rst_req"}, int'(rreq), int'(m_rst));
    if (irq) n_irq++;
    if (rreq) n_rst++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input logic [3:0] p, input logic [1:0] w, input logic ie);
    @(negedge clk);
    rst_n = 1'b0; psel = p; wsel = w; ien = ie;
    step(2);
    n_irq = 0; n_rst = 0;
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_cnt(input int v);
    while (m_cnt != v) @(negedge clk);
  endtask

  initial begin
    // R1: reset state
    step(2);
    chk(irq == 1'b0, "R1 irq in reset", int'(irq), 0);
    chk(rreq == 1'b0, "R1 rst_req in reset", int'(rreq), 0);

    // R3/R8/R11: free-running overflow with interrupt
    tag = "R3"; tick_on = 1;
    do_reset(4'd0, 2'd3, 1'b1);
    step(130);
    chk(n_irq == 1, "R8 one irq per period", n_irq, 1);
    chk(n_rst == 1, "R3 overflow at 128 ticks", n_rst, 1);
    tag = "R11"; step(100);
    chk(n_irq == 2, "R11 irq re-armed after overflow", n_irq, 2);

    // R9: interrupt disabled
    tag = "R9";
    do_reset(4'd0, 2'd3, 1'b0);
    step(140);
    chk(n_irq == 0, "R9 no irq when disabled", n_irq, 0);
    chk(n_rst == 1, "R9 overflow still happens", n_rst, 1);

    // R4/R5/R6: 25% window, limit 96
    tag = "R6";
    do_reset(4'd0, 2'd0, 1'b0);
    wait_cnt(50); wr(8'hAC); step(3);
    chk(n_rst == 1, "R6 key in closed window", n_rst, 1);
    tag = "R4";
    wait_cnt(95); wr(8'hAC); step(3);
    chk(n_rst == 2, "R4 25% limit minus one closed", n_rst, 2);
    tag = "R5";
    wait_cnt(96); wr(8'hAC); step(3);
    chk(n_rst == 2, "R5 25% limit open", n_rst, 2);

    // R4: 50% window, limit 64
    tag = "R4";
    do_reset(4'd0, 2'd1, 1'b0);
    wait_cnt(63); wr(8'hAC); step(3);
    chk(n_rst == 1, "R4 50% count 63 closed", n_rst, 1);
    wait_cnt(64); wr(8'hAC); step(3);
    chk(n_rst == 1, "R4 50% count 64 open", n_rst, 1);

    // R4: 75% window, limit 32
    do_reset(4'd0, 2'd2, 1'b0);
    wait_cnt(31); wr(8'hAC); step(3);
    chk(n_rst == 1, "R4 75% count 31 closed", n_rst, 1);
    wait_cnt(32); wr(8'hAC); step(3);
    chk(n_rst == 1, "R4 75% count 32 open", n_rst, 1);

    // R4/R5/R7: 100% window
    do_reset(4'd0, 2'd3, 1'b0);
    wait_cnt(1); wr(8'hAC); step(3);
    chk(n_rst == 0, "R4 100% count 1 open", n_rst, 0);
    tag = "R7";
    wait_cnt(100); wr(8'h55); step(3);
    chk(n_rst == 1, "R7 wrong key 0x55", n_rst, 1);
    wait_cnt(120); wr(8'hCA); step(3);
    chk(n_rst == 2, "R7 wrong key 0xCA", n_rst, 2);

    // R10: refresh together with final tick
    tag = "R10";
    wait_cnt(127); wr(8'hAC); step(5);
    chk(n_rst == 2, "R10 write beats overflow tick", n_rst, 2);

    // R3: sparse tick, one per 4 cycles
    tag = "R3"; sparse = 1;
    do_reset(4'd0, 2'd3, 1'b0);
    step(400);
    chk(n_rst == 0, "R3 sparse tick no early overflow", n_rst, 0);
    step(200);
    chk(n_rst == 1, "R3 sparse tick overflow", n_rst, 1);
    sparse = 0;

    // R2: first-edge write ignored, later config change ignored
    tag = "R2";
    @(negedge clk);
    rst_n = 1'b0; psel = 4'd0; wsel = 2'd3; ien = 1'b0;
    wr_en = 1'b1; wr_data = 8'h00;
    step(2); n_irq = 0; n_rst = 0;
    rst_n = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    psel = 4'd5; wsel = 2'd0; ien = 1'b1;
    step(3);
    chk(n_rst == 0, "R2 write at capture edge ignored", n_rst, 0);
    step(130);
    chk(n_rst == 1, "R2 period kept after config change", n_rst, 1);
    chk(n_irq == 0, "R2 irq enable change ignored", n_irq, 0);

    // R2: exponent 8
    do_reset(4'd1, 2'd3, 1'b0);
    step(200);
    chk(n_rst == 0, "R2 code 1 not at 128", n_rst, 0);
    step(60);
    chk(n_rst == 1, "R2 code 1 overflow at 256", n_rst, 1);

    // R2: clamped code selects exponent 16
    do_reset(4'd12, 2'd3, 1'b0);
    step(65530);
    chk(n_rst == 0, "R2 clamp no early overflow", n_rst, 0);
    step(10);
    chk(n_rst == 1, "R2 clamp overflow at 65536", n_rst, 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule